// File: doc/BRIEF.md
# Four-Mode Universal Shift Register

This block is a small synchronous register, four bits wide by default, whose action on each rising clock edge is picked by a two-bit mode code. The register can keep its value, shift toward its low end while a serial bit enters at the top, shift toward its top end while a different serial bit enters at the low end, or take a whole parallel word in one edge. The two serial inputs are separate pins, so one instance can shift in either direction without any muxing around it.

The top bit `regOut[WIDTH-1]` is the first cell of the chain and the bottom bit `regOut[0]` is the last. An active-low clear empties the register at once, whatever the clock or the mode is doing. The usual uses are serial-to-parallel and parallel-to-serial conversion, and simple bidirectional shifting inside a datapath.

Top module: `shiftRegUniversal`

## Requirements
- R1: While `clrN` is low, `regOut` is all zeros. The clear takes effect as soon as `clrN` falls, without waiting for a clock edge.
- R2: With `modeSel` = 2'b00, a rising clock edge leaves `regOut` unchanged, whatever is on `serRight`, `serLeft` and `parIn`.
- R3: With `modeSel` = 2'b01, a rising edge moves every bit one place toward bit 0. Bit i takes the old bit i+1, and bit WIDTH-1 takes `serRight`.
- R4: With `modeSel` = 2'b10, a rising edge moves every bit one place toward bit WIDTH-1. Bit i takes the old bit i-1, and bit 0 takes `serLeft`.
- R5: With `modeSel` = 2'b11, a rising edge copies `parIn` into `regOut` bit for bit, so `parIn[WIDTH-1]` lands in the first cell.
- R6: The inputs a mode does not name have no effect on the result. A right shift ignores `serLeft` and `parIn`, a left shift ignores `serRight` and `parIn`, and a load ignores both serial inputs.
- R7: Changes on `modeSel`, `serRight`, `serLeft` and `parIn` between clock edges do not change `regOut`. Only the values present at the rising edge count.
- R8: While `clrN` is low, clock edges in any mode leave `regOut` at zero. The clear outranks every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clrN | input | 1 | Asynchronous clear, active low |
| modeSel | input | 2 | 00 hold, 01 shift toward bit 0, 10 shift toward top bit, 11 parallel load |
| serRight | input | 1 | Serial bit entering the top bit on a mode 01 shift |
| serLeft | input | 1 | Serial bit entering bit 0 on a mode 10 shift |
| parIn | input | WIDTH | Parallel word loaded in mode 11 |
| regOut | output | WIDTH | Current register contents |

## Verification
The bench first loads every one of the sixteen starting values. It then applies each of the four modes with every parallel word and every combination of the two serial bits. This shows that each mode reads only its own inputs: a right shift that picked up the left serial pin, for example, would disagree with the expected value for half of the serial combinations. In the middle of each cycle the inputs are set to unrelated values and the output is checked for no change, which separates edge-triggered capture from a transparent path. The clear is asserted away from any edge to show it acts at once, and it is then held through clock edges in load mode to show it outranks the mode code.

// File: rtl/shiftRegPkg.sv
package shiftRegPkg;

  typedef enum logic [1:0] {
    MODE_HOLD  = 2'b00,
    MODE_RIGHT = 2'b01,
    MODE_LEFT  = 2'b10,
    MODE_LOAD  = 2'b11
  } shiftMode_e;

  typedef struct packed {
    logic hold;
    logic shiftRight;
    logic shiftLeft;
    logic load;
  } shiftStrobes_t;

endpackage

// File: rtl/shiftControl.sv
module shiftControl
  import shiftRegPkg::*;
(
  input  logic          clk,
  input  logic          clrN,
  input  logic [1:0]    modeSel,
  output shiftStrobes_t strb
);

  shiftMode_e modeCode;

  assign modeCode = shiftMode_e'(modeSel);

  always_comb begin
    strb = '0;
    case (modeCode)
      MODE_HOLD:  strb.hold       = 1'b1;
      MODE_RIGHT: strb.shiftRight = 1'b1;
      MODE_LEFT:  strb.shiftLeft  = 1'b1;
      MODE_LOAD:  strb.load       = 1'b1;
      default:    strb.hold       = 1'b1;
    endcase
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!clrN)
    $countones(strb) == 1); // R6

endmodule

// File: rtl/shiftDatapath.sv
module shiftDatapath
  import shiftRegPkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clrN,
  input  shiftStrobes_t    strb,
  input  logic             serRight,
  input  logic             serLeft,
  input  logic [WIDTH-1:0] parIn,
  output logic [WIDTH-1:0] regOut
);

  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] stateQ;
  logic [WIDTH-1:0] nextQ;
  logic             armed;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    logic fromAbove;
    logic fromBelow;

    if (i == TOP) begin : g_top
      assign fromAbove = serRight;
    end else begin : g_mid_hi
      assign fromAbove = stateQ[i+1];
    end

    if (i == 0) begin : g_bot
      assign fromBelow = serLeft;
    end else begin : g_mid_lo
      assign fromBelow = stateQ[i-1];
    end

    always_comb begin
      nextQ[i] = stateQ[i];
      if (strb.load)            nextQ[i] = parIn[i];
      else if (strb.shiftLeft)  nextQ[i] = fromBelow;
      else if (strb.shiftRight) nextQ[i] = fromAbove;
    end
  end

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) stateQ <= '0;
    else       stateQ <= nextQ;
  end

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  assign regOut = stateQ;

  AST_CLEAR_ZERO: assert property (@(negedge clk)
    !clrN |-> (regOut == '0)); // R1

  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!clrN)
    (armed && strb.hold) |=> $stable(regOut)); // R2

  AST_RIGHT_SHIFT: assert property (@(posedge clk) disable iff (!clrN)
    (armed && strb.shiftRight) |=>
      (regOut == {$past(serRight), $past(regOut[TOP:1])})); // R3

  AST_LEFT_SHIFT: assert property (@(posedge clk) disable iff (!clrN)
    (armed && strb.shiftLeft) |=>
      (regOut == {$past(regOut[TOP-1:0]), $past(serLeft)})); // R4

  AST_PAR_LOAD: assert property (@(posedge clk) disable iff (!clrN)
    (armed && strb.load) |=> (regOut == $past(parIn))); // R5

endmodule

// File: rtl/shiftRegUniversal.sv
module shiftRegUniversal
  import shiftRegPkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clrN,
  input  logic [1:0]       modeSel,
  input  logic             serRight,
  input  logic             serLeft,
  input  logic [WIDTH-1:0] parIn,
  output logic [WIDTH-1:0] regOut
);

  shiftStrobes_t strb;

  shiftControl u_ctrl (
    .clk     (clk),
    .clrN    (clrN),
    .modeSel (modeSel),
    .strb    (strb)
  );

  shiftDatapath #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .clrN     (clrN),
    .strb     (strb),
    .serRight (serRight),
    .serLeft  (serLeft),
    .parIn    (parIn),
    .regOut   (regOut)
  );

endmodule

// File: tb/shiftRegUniversal_tb.sv
module shiftRegUniversal_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WIDTH      = 4;

  logic             clk = 1'b0;
  logic             clrN;
  logic [1:0]       modeSel;
  logic             serRight;
  logic             serLeft;
  logic [WIDTH-1:0] parIn;
  logic [WIDTH-1:0] regOut;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  shiftRegUniversal #(.WIDTH(WIDTH)) u_dut (
    .clk      (clk),
    .clrN     (clrN),
    .modeSel  (modeSel),
    .serRight (serRight),
    .serLeft  (serLeft),
    .parIn    (parIn),
    .regOut   (regOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [WIDTH-1:0] act,
                       input logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [WIDTH-1:0] model(input int m, input int cur,
      input int sr, input int sl, input int d);
    int r;
    case (m)
      0: r = cur;
      1: r = (cur >> 1) + sr * (1 << (WIDTH-1));
      2: r = ((cur * 2) % (1 << WIDTH)) + sl;
      default: r = d;
    endcase
    return r[WIDTH-1:0];
  endfunction

  task automatic driveEdge(input int m, input int sr, input int sl, input int d);
    modeSel  = m[1:0];
    serRight = sr[0];
    serLeft  = sl[0];
    parIn    = d[WIDTH-1:0];
    @(posedge clk);
    #2;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired actual=%h expected=%h", regOut, regOut);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    clrN = 1'b0; modeSel = 2'b11; serRight = 1'b1; serLeft = 1'b1; parIn = '1;
    #3;
    check("R1 reset", regOut, '0);
    @(posedge clk); #2;
    @(posedge clk); #2;
    check("R8 clear outranks load", regOut, '0);
    clrN = 1'b1;
    #2;

    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 16; s++) begin
        for (int d = 0; d < 16; d++) begin
          for (int b = 0; b < 4; b++) begin
            driveEdge(3, b & 1, b >> 1, s);
            check("R5 load start", regOut, s[WIDTH-1:0]);
            modeSel  = 2'(~m);
            serRight = ~serRight;
            serLeft  = ~serLeft;
            parIn    = ~parIn;
            #2;
            check("R7 mid-cycle change", regOut, s[WIDTH-1:0]);
            driveEdge(m, b & 1, b >> 1, d);
            case (m)
              0: check("R2 R6 hold", regOut, model(m, s, b & 1, b >> 1, d));
              1: check("R3 R6 right", regOut, model(m, s, b & 1, b >> 1, d));
              2: check("R4 R6 left", regOut, model(m, s, b & 1, b >> 1, d));
              default: check("R5 R6 load", regOut, model(m, s, b & 1, b >> 1, d));
            endcase
          end
        end
      end
    end

    driveEdge(3, 0, 0, 4'hB);
    check("R5 preload", regOut, 4'hB);
    #1;
    clrN = 1'b0;
    #1;
    check("R1 async clear", regOut, '0);
    for (int k = 0; k < 3; k++) begin
      driveEdge(k + 1, 1, 1, 4'hF);
      check("R8 clear holds", regOut, '0);
    end
    clrN = 1'b1;
    driveEdge(1, 1, 0, 0);
    check("R3 after clear", regOut, 4'h8);
    driveEdge(2, 0, 1, 0);
    check("R4 after clear", regOut, 4'h1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule